// File: doc/BRIEF.md
# Paced Transmit Word Buffer

This block sits on the write side of a serial port, between a host DMA engine and the port's transmit path. It stores 32-bit words and paces the requests it sends to the host. A request goes out only when the buffer has room for a whole programmed event of words. After that, the block waits until the host has delivered the full event before it checks free space again. One host request can therefore feed several smaller transfers on the port side, and the buffer tends to stay full.

On the port side, each transmit request from the port takes out a programmed chunk of words, one word per cycle, in arrival order. If too few words are stored, the port request waits until enough arrive. When the buffer is disabled, the block becomes transparent: the port's request, the host's write strobe and the host's data pass straight through, and the storage is flushed. A configuration check rejects an event size that is zero, larger than the storage, or not a whole multiple of the chunk size. While that check fails, the block raises no paced request and hands out no chunk.

Top module: `txfifo_pacer`

## Requirements
- R1: While reset is held, hostReq and portValid are 0.
- R2: With the buffer enabled and the configuration valid, hostReq is a one-cycle pulse. It is issued whenever no event is outstanding and free space is at least evtSize words.
- R3: After a pulse, no further pulse is issued until evtSize accepted host words have been written since that pulse.
- R4: No pulse is issued while free space is below evtSize, even when no event is outstanding.
- R5: A port request makes portValid high for exactly dmaSize consecutive cycles. It delivers the oldest stored words in write order, one word per cycle on portData.
- R6: A port request that arrives while fewer than dmaSize words are stored stays pending. It is served as soon as dmaSize words are present.
- R7: With fifoEn at 0, hostReq follows portReq, and portValid and portData follow hostWrEn and hostWrData, in the same cycle. The stored words are discarded, so after re-enabling no stale word is ever delivered.
- R8: cfgErr is 1 exactly when evtSize is 0, dmaSize is 0, evtSize exceeds the storage depth, or evtSize is not a whole multiple of dmaSize. While cfgErr is 1, no paced pulse is issued and no chunk is delivered.
- R9: A host write that arrives while the storage is full is dropped and never delivered.
- R10: With evtSize equal to dmaSize (no pacing), a new pulse follows every dmaSize accepted writes as long as space remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1: buffered and paced; 0: transparent pass-through |
| evtSize | input | $clog2(DEPTH+1) | Words per host event |
| dmaSize | input | $clog2(DEPTH+1) | Words per port chunk |
| cfgErr | output | 1 | Illegal size combination |
| hostWrEn | input | 1 | Host word-write strobe |
| hostWrData | input | DATA_W | Host write word |
| hostReq | output | 1 | Transmit request toward the host |
| portReq | input | 1 | Transmit request from the port |
| portValid | output | 1 | A word is presented to the port this cycle |
| portData | output | DATA_W | Word presented to the port |

## Verification
The bench builds the block with an eight-word store. This makes filling it to the brim, dropping an overflow write and draining it back to an empty state take only a few dozen cycles. Most scenarios use an event of four words and chunks of two, so a single request spans two port chunks. The bench also runs equal sizes to cover the unpaced setting. Its configuration sweep reaches each rejected case: zero, a non-multiple, and an event larger than the store.

// File: rtl/txpace_pkg.sv
package txpace_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } txStrobe_t;
endpackage

// File: rtl/txpace_datapath.sv
module txpace_datapath
  import txpace_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  txStrobe_t                    strobe,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign rdData = store[rdPtr];
endmodule

// File: rtl/txpace_ctrl.sv
module txpace_ctrl
  import txpace_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fifoEn,
  input  logic [$clog2(DEPTH+1)-1:0]   evtSize,
  input  logic [$clog2(DEPTH+1)-1:0]   dmaSize,
  input  logic                         hostWrEn,
  input  logic                         portReq,
  input  logic [$clog2(DEPTH+1)-1:0]   level,
  output txStrobe_t                    strobe,
  output logic                         cfgErr,
  output logic                         pacedReq,
  output logic                         popActive
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             outstanding;
  logic [CNT_W-1:0] evtCnt;
  logic             pending;
  logic [CNT_W-1:0] popRemain;
  logic [CNT_W-1:0] freeSpace;
  logic             raise, startChunk, push, pop, modBad;

  always_comb begin
    modBad    = (dmaSize != '0) && ((evtSize % dmaSize) != '0);
    cfgErr    = (evtSize == '0) || (dmaSize == '0) || (evtSize > DEPTH_C) || modBad;
    freeSpace = DEPTH_C - level;
    push      = fifoEn && hostWrEn && (level != DEPTH_C);
    pop       = fifoEn && (popRemain != '0);
    raise     = fifoEn && !cfgErr && !outstanding && (freeSpace >= evtSize);
    startChunk = fifoEn && !cfgErr && pending && (popRemain == '0) && (level >= dmaSize);
    strobe.push  = push;
    strobe.pop   = pop;
    strobe.flush = !fifoEn;
    popActive    = pop;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !fifoEn) begin
      outstanding <= 1'b0;
      evtCnt      <= '0;
      pacedReq    <= 1'b0;
      pending     <= 1'b0;
      popRemain   <= '0;
    end else begin
      pacedReq <= raise;
      if (raise) begin
        outstanding <= 1'b1;
        evtCnt      <= '0;
      end else if (outstanding && push) begin
        if (evtCnt == evtSize - CNT_W'(1)) begin
          outstanding <= 1'b0;
          evtCnt      <= '0;
        end else begin
          evtCnt <= evtCnt + CNT_W'(1);
        end
      end
      pending <= (pending && !startChunk) || portReq;
      if (startChunk)  popRemain <= dmaSize;
      else if (pop)    popRemain <= popRemain - CNT_W'(1);
    end
  end
endmodule

// File: rtl/txfifo_pacer.sv
module txfifo_pacer
  import txpace_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fifoEn,
  input  logic [$clog2(DEPTH+1)-1:0]   evtSize,
  input  logic [$clog2(DEPTH+1)-1:0]   dmaSize,
  output logic                         cfgErr,
  input  logic                         hostWrEn,
  input  logic [DATA_W-1:0]            hostWrData,
  output logic                         hostReq,
  input  logic                         portReq,
  output logic                         portValid,
  output logic [DATA_W-1:0]            portData
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  txStrobe_t         strobe;
  logic [CNT_W-1:0]  level;
  logic [DATA_W-1:0] rdData;
  logic              pacedReq, popActive;

  txpace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .evtSize(evtSize), .dmaSize(dmaSize),
    .hostWrEn(hostWrEn), .portReq(portReq), .level(level), .strobe(strobe),
    .cfgErr(cfgErr), .pacedReq(pacedReq), .popActive(popActive)
  );

  txpace_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(hostWrData),
    .rdData(rdData), .level(level)
  );

  assign hostReq   = fifoEn ? pacedReq  : portReq;
  assign portValid = fifoEn ? popActive : hostWrEn;
  assign portData  = fifoEn ? rdData    : hostWrData;
endmodule

// File: rtl/txpace_chk.sv
module txpace_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       fifoEn,
  input logic [$clog2(DEPTH+1)-1:0] evtSize,
  input logic [$clog2(DEPTH+1)-1:0] dmaSize,
  input logic                       cfgErr,
  input logic                       hostWrEn,
  input logic                       hostReq,
  input logic                       portValid
);
  logic        armed;
  logic [15:0] wrSince;
  logic [15:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN || !fifoEn) begin
      armed   <= 1'b0;
      wrSince <= '0;
      runLen  <= '0;
    end else begin
      if (hostReq) begin
        armed   <= 1'b1;
        wrSince <= '0;
      end else if (hostWrEn) begin
        wrSince <= wrSince + 16'd1;
      end
      runLen <= portValid ? runLen + 16'd1 : '0;
    end
  end

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && hostReq) |=> (!fifoEn || !hostReq));

  // R3
  event_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && hostReq && armed) |-> (wrSince >= 16'(evtSize)));

  // R5
  chunk_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && portValid) |-> (runLen < 16'(dmaSize)));

  // R7
  enable_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoEn) |-> !portValid);

  // R8
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && cfgErr) |=> (!fifoEn || !hostReq));
endmodule

bind txfifo_pacer txpace_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .evtSize(evtSize), .dmaSize(dmaSize),
  .cfgErr(cfgErr), .hostWrEn(hostWrEn), .hostReq(hostReq), .portValid(portValid)
);

// File: tb/tb_txfifo_pacer.sv
`timescale 1ns/1ps
module tb_txfifo_pacer;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          fifoEn = 1'b1;
  logic [CW-1:0] evtSize = CW'(4);
  logic [CW-1:0] dmaSize = CW'(2);
  logic          cfgErr;
  logic          hostWrEn = 1'b0;
  logic [31:0]   hostWrData = '0;
  logic          hostReq;
  logic          portReq = 1'b0;
  logic          portValid;
  logic [31:0]   portData;

  int checks = 0;
  int fails  = 0;
  int reqCount = 0;
  logic [31:0] gotQ [$];

  always #10 clk = ~clk;

  txfifo_pacer #(.DATA_W(32), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .evtSize(evtSize), .dmaSize(dmaSize),
    .cfgErr(cfgErr), .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostReq(hostReq),
    .portReq(portReq), .portValid(portValid), .portData(portData)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (hostReq) reqCount++;
      if (portValid) gotQ.push_back(portData);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  task automatic doReset(input logic en, input int evt, input int dma);
    rstN = 1'b0; fifoEn = en; evtSize = CW'(evt); dmaSize = CW'(dma);
    hostWrEn = 1'b0; portReq = 1'b0;
    idle(3);
    check(hostReq == 1'b0 && portValid == 1'b0, "R1 reset outputs",
          {30'd0, hostReq, portValid}, 32'd0);
    rstN = 1'b1;
    reqCount = 0;
    gotQ.delete();
  endtask

  task automatic writeWord(input logic [31:0] d);
    hostWrEn = 1'b1; hostWrData = d;
    tick();
    hostWrEn = 1'b0;
  endtask

  task automatic portPulse();
    portReq = 1'b1;
    tick();
    portReq = 1'b0;
  endtask

  task automatic testPacing();
    bit ok;
    doReset(1'b1, 4, 2);
    idle(5);
    check(reqCount == 1, "R2 first paced request", reqCount, 1);
    idle(10);
    check(reqCount == 1, "R3 no repeat while outstanding", reqCount, 1);
    for (int i = 0; i < 3; i++) writeWord(32'hA000_0000 + i);
    idle(5);
    check(reqCount == 1, "R3 partial event holds request", reqCount, 1);
    writeWord(32'hA000_0003);
    idle(5);
    check(reqCount == 2, "R3 rearm after full event", reqCount, 2);
    for (int i = 4; i < 8; i++) writeWord(32'hA000_0000 + i);
    idle(10);
    check(reqCount == 2, "R4 no request when full", reqCount, 2);
    writeWord(32'hBAD0_BAD0);
    portPulse();
    idle(6);
    check(gotQ.size() == 2 && gotQ[0] == 32'hA000_0000 && gotQ[1] == 32'hA000_0001,
          "R5 first chunk order", gotQ.size() > 1 ? gotQ[1] : 32'hX, 32'hA000_0001);
    check(reqCount == 2, "R4 free space below event size", reqCount, 2);
    portPulse();
    idle(6);
    check(gotQ.size() == 4, "R5 second chunk size", gotQ.size(), 4);
    check(reqCount == 3, "R2 request after drain", reqCount, 3);
    portPulse();
    idle(6);
    portPulse();
    idle(6);
    ok = (gotQ.size() == 8);
    for (int i = 0; i < 8 && ok; i++) ok = (gotQ[i] == 32'hA000_0000 + i);
    check(ok, "R9 overflow word dropped", gotQ.size() > 7 ? gotQ[7] : 32'hX, 32'hA000_0007);
  endtask

  task automatic testPending();
    doReset(1'b1, 4, 2);
    idle(3);
    portPulse();
    idle(8);
    check(gotQ.size() == 0, "R6 pending with empty store", gotQ.size(), 0);
    writeWord(32'hC000_0000);
    idle(5);
    check(gotQ.size() == 0, "R6 pending with one word", gotQ.size(), 0);
    writeWord(32'hC000_0001);
    idle(6);
    check(gotQ.size() == 2 && gotQ[0] == 32'hC000_0000 && gotQ[1] == 32'hC000_0001,
          "R6 served once chunk present", gotQ.size(), 2);
  endtask

  task automatic testNoPace();
    doReset(1'b1, 2, 2);
    idle(5);
    check(reqCount == 1, "R10 first request", reqCount, 1);
    writeWord(32'hD000_0000);
    writeWord(32'hD000_0001);
    idle(5);
    check(reqCount == 2, "R10 request per chunk", reqCount, 2);
    writeWord(32'hD000_0002);
    writeWord(32'hD000_0003);
    idle(5);
    check(reqCount == 3, "R10 request per chunk again", reqCount, 3);
  endtask

  task automatic testCfg();
    doReset(1'b1, 3, 2);
    idle(10);
    check(cfgErr == 1'b1, "R8 non-multiple flagged", cfgErr, 1);
    check(reqCount == 0, "R8 no request on bad config", reqCount, 0);
    writeWord(32'hE000_0000);
    writeWord(32'hE000_0001);
    portPulse();
    idle(8);
    check(gotQ.size() == 0, "R8 no chunk on bad config", gotQ.size(), 0);
    evtSize = CW'(0); #1;
    check(cfgErr == 1'b1, "R8 zero event flagged", cfgErr, 1);
    evtSize = CW'(9); dmaSize = CW'(3); #1;
    check(cfgErr == 1'b1, "R8 event above depth flagged", cfgErr, 1);
    evtSize = CW'(4); dmaSize = CW'(0); #1;
    check(cfgErr == 1'b1, "R8 zero chunk flagged", cfgErr, 1);
    evtSize = CW'(8); dmaSize = CW'(4); #1;
    check(cfgErr == 1'b0, "R8 legal multiple accepted", cfgErr, 0);
  endtask

  task automatic testBypass();
    doReset(1'b1, 4, 2);
    idle(3);
    for (int i = 0; i < 3; i++) writeWord(32'hF000_0000 + i);
    fifoEn = 1'b0;
    portReq = 1'b1; #1;
    check(hostReq == 1'b1, "R7 request passes through", hostReq, 1);
    portReq = 1'b0; #1;
    check(hostReq == 1'b0, "R7 request low passes through", hostReq, 0);
    hostWrEn = 1'b1; hostWrData = 32'h1234_5678; #1;
    check(portValid == 1'b1 && portData == 32'h1234_5678, "R7 data passes through",
          portData, 32'h1234_5678);
    hostWrEn = 1'b0;
    tick();
    fifoEn = 1'b1;
    idle(3);
    gotQ.delete();
    portPulse();
    idle(8);
    check(gotQ.size() == 0, "R7 stored words flushed", gotQ.size(), 0);
    writeWord(32'h5500_0000);
    writeWord(32'h5500_0001);
    idle(6);
    check(gotQ.size() == 2 && gotQ[0] == 32'h5500_0000 && gotQ[1] == 32'h5500_0001,
          "R7 only fresh words after enable", gotQ.size() > 0 ? gotQ[0] : 32'hX, 32'h5500_0000);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    testPacing();
    testPending();
    testNoPace();
    testCfg();
    testBypass();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule